// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Recognition

This block turns an asynchronous serial line into received words and status flags. Each frame has a low start bit, then 8 data bits (or 9 when the wide-frame mode input is high) least significant bit first, then a high stop bit. The line is sampled on an oversampling tick that runs OVS times per bit. Each bit value is the majority of three samples taken around the middle of the bit. If those three samples disagree, the noise flag is raised.

A break is a run of zero bits as long as a whole frame: 10 bits in 8-bit mode, or 11 in 9-bit mode. The break-recognition enable picks how a break is reported. With the enable low, a break is treated as a received frame that failed its stop bit: the framing flag and the data-full flag are set and the data register is cleared. With the enable high, a break only raises a dedicated break flag. The received data and the data-full, overrun, framing and parity flags are left as they were. In this mode the run of zeros is counted even when it begins inside a data byte, so a break that starts part-way through a frame is still recognised.

Software reads the data with a read strobe, which clears the per-frame flags. It clears the break flag with a separate acknowledge strobe.

Top module: `uart_brk_rx`

## Requirements
- R1: In 8-bit mode (`wide_mode`=0), a frame of start 0, eight data bits sent LSB first and stop 1 sets `rdrf`. The data appears on `rx_data[7:0]` with `rx_data[8]`=0, and `fe`=0.
- R2: In 9-bit mode (`wide_mode`=1), nine data bits are received LSB first. They appear on `rx_data[8:0]`.
- R3: With `par_en`=1, the last data bit is an even parity bit. `pe` is set when the received data bits, parity bit included, hold an odd number of ones. With `par_en`=0, `pe` stays 0.
- R4: Each bit is the majority of the samples at phases OVS/2-1, OVS/2 and OVS/2+1 of that bit. Disagreement among them sets `nf` without changing the decided bit.
- R5: A frame that completes while `rdrf` is 1 sets `ovr`. Its data is discarded, and `rx_data` keeps the earlier word.
- R6: `rd_stb` clears `rdrf`, `fe`, `pe`, `nf` and `ovr`, and leaves `rx_data` unchanged.
- R7: With `brk_en`=0, 10 zero bits (8-bit mode) or 11 zero bits (9-bit mode) counted from the start bit set `fe` and `rdrf` and clear `rx_data` to 0.
- R8: With `brk_en`=1, the same run of zeros from the start bit sets `bkdif`. It leaves `rx_data`, `rdrf`, `fe`, `pe` and `ovr` unchanged. A 9-bit frame of all-zero data with a high stop bit has only 10 zeros, so it is received normally and is not a break.
- R9: With `brk_en`=1, a zero run that starts inside the data bits and carries on past the stop position until it reaches the break length sets `bkdif`. No frame is delivered.
- R10: With `brk_en`=1, a low stop bit followed by a high bit before the break length is reached completes the frame with `fe`=1, `rdrf`=1 and the data bits received.
- R11: `raf` goes high once a start bit is seen and stays high through the frame. During a break it stays high until the line returns to 1.
- R12: `brk_ack` clears `bkdif`.
- R13: After a low stop bit or a break, the receiver starts no new frame until the line has been sampled high. Zeros that follow therefore deliver no frame and raise no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| tick | input | 1 | Oversampling strobe, OVS per bit time |
| wide_mode | input | 1 | 0: 8 data bits, 1: 9 data bits |
| brk_en | input | 1 | Selects the dedicated break-flag path |
| par_en | input | 1 | Last data bit is even parity |
| rd_stb | input | 1 | Data read: clears per-frame flags |
| brk_ack | input | 1 | Clears the break flag |
| rx_data | output | DBITS+1 | Received word |
| rdrf | output | 1 | Receive data full |
| fe | output | 1 | Framing error |
| ovr | output | 1 | Overrun |
| pe | output | 1 | Parity error |
| nf | output | 1 | Noise seen in the frame |
| raf | output | 1 | Receiver active |
| bkdif | output | 1 | Break recognised |

## Verification
Every cycle, the assertions check how the flag logic answers a completed frame or a recognised break. A dedicated break must leave the data and error flags stable. A break on the frame-error path must leave zero data with framing and full set. An overrun must keep the earlier word. The read and acknowledge strobes must clear their flags. Only the bench scenarios show which bit patterns give those events in the first place: the exact zero-run length in each frame width, a break that begins mid-byte, recovery from a low stop bit, majority voting against a single noisy sample, and the refusal to restart on a line held low.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACT   = 2'd1,
    ST_ZHOLD = 2'd2,
    ST_BWAIT = 2'd3
  } rx_st_t;
endpackage

// File: rtl/rxb_sampler.sv
module rxb_sampler #(
  parameter int OVS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rx,
  input  logic restart,
  output logic rx_s,
  output logic bit_stb,
  output logic bit_val,
  output logic bit_nz
);
  localparam int PW = (OVS > 1) ? $clog2(OVS) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(OVS - 1);
  localparam logic [PW-1:0] PH_V0   = PW'(OVS / 2 - 1);
  localparam logic [PW-1:0] PH_V1   = PW'(OVS / 2);
  localparam logic [PW-1:0] PH_V2   = PW'(OVS / 2 + 1);

  logic          s1;
  logic [PW-1:0] ph;
  logic          v0, v1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1      <= 1'b1;
      rx_s    <= 1'b1;
      ph      <= '0;
      v0      <= 1'b1;
      v1      <= 1'b1;
      bit_stb <= 1'b0;
      bit_val <= 1'b1;
      bit_nz  <= 1'b0;
    end else begin
      s1      <= rx;
      rx_s    <= s1;
      bit_stb <= 1'b0;
      if (tick) begin
        if (restart) begin
          ph <= PW'(1);
        end else begin
          ph <= (ph == PH_LAST) ? '0 : ph + PW'(1);
          if (ph == PH_V0) v0 <= rx_s;
          if (ph == PH_V1) v1 <= rx_s;
          if (ph == PH_V2) begin
            bit_stb <= 1'b1;
            bit_val <= (v0 & v1) | (v0 & rx_s) | (v1 & rx_s);
            bit_nz  <= !((v0 == v1) && (v1 == rx_s));
          end
        end
      end
    end
  end

  // R4
  stb_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    bit_stb |=> !bit_stb);

  initial begin
    if (OVS < 4) $error("OVS must be at least 4");
  end
endmodule

// File: rtl/rxb_framer.sv
module rxb_framer
  import uart_brk_pkg::*;
#(
  parameter int DBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             rx_s,
  input  logic             bit_stb,
  input  logic             bit_val,
  input  logic             bit_nz,
  input  logic             wide_mode,
  input  logic             brk_en,
  input  logic             par_en,
  output logic             restart,
  output logic             done,
  output logic             brk,
  output logic             leg_brk,
  output logic [DBITS:0]   frm_data,
  output logic             frm_fe,
  output logic             frm_pe,
  output logic             frm_nf,
  output logic             active
);
  localparam int SHW = DBITS + 1;
  localparam int CW  = $clog2(DBITS + 4);

  rx_st_t         st;
  logic [CW-1:0]  idx;
  logic [CW-1:0]  zrun;
  logic           nacc;
  logic [SHW-1:0] sh;

  logic [CW-1:0]  nb, blen, zn;
  logic           nz_acc;
  logic [SHW-1:0] data_cur;

  always_comb begin
    nb       = wide_mode ? CW'(SHW) : CW'(DBITS);
    blen     = nb + CW'(2);
    zn       = bit_val ? '0 : zrun + CW'(1);
    nz_acc   = nacc | bit_nz;
    data_cur = wide_mode ? sh : {1'b0, sh[DBITS-1:0]};
    restart  = (st == ST_IDLE) && tick && !rx_s;
    active   = (st != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      idx      <= '0;
      zrun     <= '0;
      nacc     <= 1'b0;
      sh       <= '0;
      done     <= 1'b0;
      brk      <= 1'b0;
      leg_brk  <= 1'b0;
      frm_data <= '0;
      frm_fe   <= 1'b0;
      frm_pe   <= 1'b0;
      frm_nf   <= 1'b0;
    end else begin
      done    <= 1'b0;
      brk     <= 1'b0;
      leg_brk <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (restart) begin
            st   <= ST_ACT;
            idx  <= '0;
            zrun <= '0;
            nacc <= 1'b0;
            sh   <= '0;
          end
        end
        ST_ACT: begin
          if (bit_stb) begin
            zrun <= zn;
            nacc <= nz_acc;
            if (idx == '0) begin
              if (bit_val) st <= ST_IDLE;
              else         idx <= CW'(1);
            end else if (idx <= nb) begin
              for (int i = 0; i < SHW; i++)
                if (idx == CW'(i + 1)) sh[i] <= bit_val;
              idx <= idx + CW'(1);
            end else begin
              frm_data <= data_cur;
              frm_pe   <= par_en & (^data_cur);
              frm_nf   <= nz_acc;
              if (bit_val) begin
                done   <= 1'b1;
                frm_fe <= 1'b0;
                st     <= ST_IDLE;
              end else if (zn == blen) begin
                if (brk_en) begin
                  brk <= 1'b1;
                end else begin
                  done    <= 1'b1;
                  leg_brk <= 1'b1;
                  frm_fe  <= 1'b1;
                end
                st <= ST_BWAIT;
              end else if (brk_en) begin
                st <= ST_ZHOLD;
              end else begin
                done   <= 1'b1;
                frm_fe <= 1'b1;
                st     <= ST_BWAIT;
              end
            end
          end
        end
        ST_ZHOLD: begin
          if (bit_stb) begin
            zrun <= zn;
            nacc <= nz_acc;
            if (bit_val) begin
              done   <= 1'b1;
              frm_fe <= 1'b1;
              frm_nf <= nz_acc;
              st     <= ST_IDLE;
            end else if (zn == blen) begin
              brk    <= 1'b1;
              frm_nf <= nz_acc;
              st     <= ST_BWAIT;
            end
          end
        end
        ST_BWAIT: begin
          if (tick && rx_s) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8
  one_event_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, brk}));

  // R8
  brk_mode_chk: assert property (@(posedge clk) disable iff (rst)
    brk |-> $past(brk_en));

  // R7
  leg_zero_chk: assert property (@(posedge clk) disable iff (rst)
    leg_brk |-> (done && frm_data == '0 && frm_fe));
endmodule

// File: rtl/uart_brk_rx.sv
module uart_brk_rx #(
  parameter int OVS   = 8,
  parameter int DBITS = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rx_in,
  input  logic           tick,
  input  logic           wide_mode,
  input  logic           brk_en,
  input  logic           par_en,
  input  logic           rd_stb,
  input  logic           brk_ack,
  output logic [DBITS:0] rx_data,
  output logic           rdrf,
  output logic           fe,
  output logic           ovr,
  output logic           pe,
  output logic           nf,
  output logic           raf,
  output logic           bkdif
);
  logic rx_s, bit_stb, bit_val, bit_nz, restart;
  logic done, brk, leg_brk, frm_fe, frm_pe, frm_nf, active;
  logic [DBITS:0] frm_data;

  rxb_sampler #(.OVS(OVS)) u_samp (
    .clk(clk), .rst(rst), .tick(tick), .rx(rx_in), .restart(restart),
    .rx_s(rx_s), .bit_stb(bit_stb), .bit_val(bit_val), .bit_nz(bit_nz)
  );

  rxb_framer #(.DBITS(DBITS)) u_frm (
    .clk(clk), .rst(rst), .tick(tick), .rx_s(rx_s),
    .bit_stb(bit_stb), .bit_val(bit_val), .bit_nz(bit_nz),
    .wide_mode(wide_mode), .brk_en(brk_en), .par_en(par_en),
    .restart(restart), .done(done), .brk(brk), .leg_brk(leg_brk),
    .frm_data(frm_data), .frm_fe(frm_fe), .frm_pe(frm_pe), .frm_nf(frm_nf),
    .active(active)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0;
      rdrf    <= 1'b0;
      fe      <= 1'b0;
      ovr     <= 1'b0;
      pe      <= 1'b0;
      nf      <= 1'b0;
      raf     <= 1'b0;
      bkdif   <= 1'b0;
    end else begin
      raf <= active;
      if (rd_stb) begin
        rdrf <= 1'b0;
        fe   <= 1'b0;
        ovr  <= 1'b0;
        pe   <= 1'b0;
        nf   <= 1'b0;
      end
      if (brk_ack) bkdif <= 1'b0;
      if (done) begin
        if (leg_brk) begin
          rx_data <= '0;
          rdrf    <= 1'b1;
          fe      <= 1'b1;
          pe      <= frm_pe;
          nf      <= frm_nf;
          if (rdrf && !rd_stb) ovr <= 1'b1;
        end else if (rdrf && !rd_stb) begin
          ovr <= 1'b1;
        end else begin
          rx_data <= frm_data;
          rdrf    <= 1'b1;
          fe      <= frm_fe;
          pe      <= frm_pe;
          nf      <= frm_nf;
        end
      end
      if (brk) begin
        bkdif <= 1'b1;
        if (frm_nf) nf <= 1'b1;
      end
    end
  end

  // R8
  brk_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (brk && !rd_stb) |=> ($stable(rx_data) && $stable(rdrf) && $stable(fe)
                          && $stable(pe) && $stable(ovr)));

  // R7
  leg_brk_chk: assert property (@(posedge clk) disable iff (rst)
    (done && leg_brk) |=> (rx_data == '0 && fe && rdrf));

  // R5
  overrun_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !leg_brk && rdrf && !rd_stb) |=> (ovr && $stable(rx_data)));

  // R6
  read_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !done && !brk) |=> (!rdrf && !fe && !pe && !ovr && !nf && $stable(rx_data)));

  // R12
  ack_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (brk_ack && !brk) |=> !bkdif);
endmodule

// File: tb/uart_brk_rx_bench.sv
module uart_brk_rx_bench;
  localparam int OVS   = 4;
  localparam int DBITS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_in = 1'b1, tick = 1'b0, wide_mode = 1'b0, brk_en = 1'b0;
  logic par_en = 1'b0, rd_stb = 1'b0, brk_ack = 1'b0;
  logic [DBITS:0] rx_data;
  logic rdrf, fe, ovr, pe, nf, raf, bkdif;

  int checks = 0;
  int errors = 0;

  uart_brk_rx #(.OVS(OVS), .DBITS(DBITS)) u_uart_brk_rx (
    .clk(clk), .rst(rst), .rx_in(rx_in), .tick(tick), .wide_mode(wide_mode),
    .brk_en(brk_en), .par_en(par_en), .rd_stb(rd_stb), .brk_ack(brk_ack),
    .rx_data(rx_data), .rdrf(rdrf), .fe(fe), .ovr(ovr), .pe(pe), .nf(nf),
    .raf(raf), .bkdif(bkdif)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [31:0] pat, input int n, input int noisy);
    for (int b = 0; b < n; b++) begin
      for (int t = 0; t < OVS; t++) begin
        @(negedge clk);
        tick  = 1'b1;
        rx_in = (b == noisy && t == 2) ? ~pat[b] : pat[b];
        @(negedge clk);
        tick = 1'b0;
      end
    end
  endtask

  task automatic idle(input int n);
    send_bits(32'hFFFF_FFFF, n, -1);
  endtask

  task automatic frame(input logic [8:0] d, input logic stopv, input int noisy);
    int nb;
    logic [31:0] pat;
    nb  = wide_mode ? 9 : 8;
    pat = 32'(d) << 1;
    pat[nb+1] = stopv;
    send_bits(pat, nb + 2, noisy);
    idle(2);
  endtask

  task automatic rd();
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [8:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R6 reset rdrf", rdrf, 0);
    check("R6 reset flags", {fe, ovr, pe, nf, bkdif}, 0);
    check("R11 reset raf", raf, 0);
    check("R1 reset data", rx_data, 0);

    // R1 / R6: full 8-bit sweep
    for (int v = 0; v < 256; v++) begin
      frame(9'(v), 1'b1, -1);
      check("R1 data", rx_data, v);
      check("R1 rdrf", {rdrf, fe}, 2'b10);
      rd();
      check("R6 read clears", {rdrf, fe, pe, nf, ovr}, 0);
      check("R6 data kept", rx_data, v);
    end

    // R2: 9-bit words
    wide_mode = 1'b1;
    for (int v = 0; v < 32; v++) begin
      d = 9'((v * 37 + 256 * (v % 2)) % 512);
      frame(d, 1'b1, -1);
      check("R2 data", rx_data, d);
      check("R2 rdrf", rdrf, 1);
      rd();
    end
    wide_mode = 1'b0;

    // R3: even parity
    par_en = 1'b1;
    for (int v = 0; v < 16; v++) begin
      d = 9'(v * 17 + 3);
      frame({1'b0, d[7:0]}, 1'b1, -1);
      check("R3 pe", pe, ^d[7:0]);
      rd();
    end
    par_en = 1'b0;

    // R4: one disagreeing mid sample
    frame(9'h0A5, 1'b1, 3);
    check("R4 nf set", nf, 1);
    check("R4 data kept by majority", rx_data, 9'h0A5);
    rd();
    check("R6 nf cleared", nf, 0);

    // R5: overrun
    frame(9'h012, 1'b1, -1);
    frame(9'h034, 1'b1, -1);
    check("R5 ovr", ovr, 1);
    check("R5 old data", rx_data, 9'h012);
    rd();
    check("R6 ovr cleared", ovr, 0);

    // R13: legacy framing error, then line held low
    send_bits({19'h0, 3'b000, 1'b0, 8'h55, 1'b0}, 13, -1);
    check("R11 raf while low after fe", raf, 1);
    idle(6);
    check("R13 fe frame", {rdrf, fe, ovr}, 3'b110);
    check("R13 fe data", rx_data, 9'h055);
    rd();

    // R7: legacy break, 8-bit
    frame(9'h03C, 1'b1, -1);
    rd();
    send_bits(32'h0, 14, -1);
    check("R11 raf during break", raf, 1);
    idle(6);
    check("R11 raf after break", raf, 0);
    check("R7 break flags", {rdrf, fe, ovr, bkdif}, 4'b1100);
    check("R7 data cleared", rx_data, 0);
    rd();

    // R7: legacy break, 9-bit
    wide_mode = 1'b1;
    frame(9'h1C3, 1'b1, -1);
    rd();
    send_bits(32'h0, 12, -1);
    idle(6);
    check("R7 9-bit break", {rdrf, fe}, 2'b11);
    check("R7 9-bit data cleared", rx_data, 0);
    rd();
    wide_mode = 1'b0;

    // R8: dedicated break path with unread data
    frame(9'h0A5, 1'b1, -1);
    brk_en = 1'b1;
    send_bits(32'h0, 12, -1);
    idle(6);
    check("R8 bkdif", bkdif, 1);
    check("R8 flags untouched", {rdrf, fe, pe, ovr}, 4'b1000);
    check("R8 data untouched", rx_data, 9'h0A5);
    @(negedge clk); brk_ack = 1'b1;
    @(negedge clk); brk_ack = 1'b0;
    @(negedge clk);
    check("R12 ack", bkdif, 0);
    rd();

    // R8 boundary: 9-bit all-zero data with high stop is a frame
    wide_mode = 1'b1;
    frame(9'h000, 1'b1, -1);
    check("R8 10 zeros in 9-bit is frame", {rdrf, fe, bkdif}, 3'b100);
    check("R8 boundary data", rx_data, 0);
    rd();
    wide_mode = 1'b0;

    // R9: break starting mid byte
    frame(9'h077, 1'b1, -1);
    rd();
    send_bits({28'h0, 4'b1110}, 16, -1);
    idle(6);
    check("R9 mid-byte bkdif", bkdif, 1);
    check("R9 no frame", {rdrf, fe, ovr}, 0);
    check("R9 data kept", rx_data, 9'h077);
    @(negedge clk); brk_ack = 1'b1;
    @(negedge clk); brk_ack = 1'b0;

    // R10: low stop then high before break length
    send_bits({21'h0, 1'b1, 1'b0, 1'b0, 8'h0F, 1'b0}, 13, -1);
    idle(6);
    check("R10 fe frame", {rdrf, fe, bkdif}, 3'b110);
    check("R10 data", rx_data, 9'h00F);
    rd();
    brk_en = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule